// File: doc/BRIEF.md
# Machine-Level Trap State Unit

This block keeps the machine-level trap state of a small 32-bit core. It holds the trap vector base and its mode, the saved return address, the trap cause, the trap value, and the three status fields that record interrupt enables and the earlier privilege level. It also tracks whether the hart is running at machine or user level. The pipeline sends a single-cycle trap request with the PC, an interrupt flag, a cause code and a value. It can also send a single-cycle return request. In the same cycle the block answers with a redirect flag and a target PC. Software reads and writes the registers through a plain address/data port.

The privilege level is a two-state machine, with states PRIV_M and PRIV_U. The TAKE_TRAP transition goes from PRIV_U to PRIV_M when a trap is accepted, and PRIV_M stays in PRIV_M on a trap. The RETURN transition leaves PRIV_M for the level saved in the previous-privilege field when a return is accepted. Each cycle also decodes exactly one event, in priority order: EV_TRAP, then EV_RET or EV_RET_BAD, then EV_WRITE, and EV_IDLE otherwise. An accepted trap or return updates every field it touches in one clock edge.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset the privilege is machine (priv_out = 2'b11). Status, return address, cause and value read as 0. The vector register reads RESET_TVEC.
- R2: A trap updates the registers on the next edge. The return address takes trap_pc with bits 1:0 forced to 0. The value register takes trap_val. The cause register reads trap_irq in bit 31 and trap_code in bits CAUSE_W-1:0, with all other bits 0.
- R3: A trap sets the previous-privilege field to the current privilege. It copies the interrupt enable into the previous-enable field, clears the interrupt enable, and moves the privilege to machine.
- R4: A trap raises redirect_valid in the same cycle. The vector register keeps the mode in bits 1:0 and the base in bits 31:2. In mode 0 the target is the base. In mode 1 an exception targets the base and an interrupt targets base + 4*trap_code.
- R5: A return accepted at machine level raises redirect_valid with the saved return address as the target. On the next edge it restores the privilege from the previous-privilege field and the interrupt enable from the previous-enable field. It then sets the previous-enable field to 1 and the previous-privilege field to user (00).
- R6: A return requested at user level changes no state and raises no redirect. It asserts mret_illegal in that cycle.
- R7: When a trap and a return arrive in the same cycle, the trap is taken, the return is dropped, and mret_illegal stays low.
- R8: A vector write always updates the base. Its mode is updated only for values 0 or 1. Values 2 and 3 keep the previous mode.
- R9: Bits 1:0 of the return address always read 0, including after a software write.
- R10: The status register has the interrupt enable in bit 3, the previous enable in bit 7 and the previous privilege in bits 12:11. A write of 01 or 10 to bits 12:11 leaves the previous privilege unchanged, while bits 3 and 7 are still written.
- R11: A software write in a cycle that carries a trap or return request is discarded.
- R12: The address map is status 0x300, vector 0x305, return address 0x341, cause 0x342 and value 0x343. Other addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_req | input | 1 | Single-cycle trap request |
| trap_pc | input | XLEN | PC to save on the trap |
| trap_irq | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_code | input | CAUSE_W | Cause code |
| trap_val | input | XLEN | Trap value (address or encoding, else 0) |
| mret_req | input | 1 | Single-cycle return request |
| redirect_valid | output | 1 | Next-PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| mret_illegal | output | 1 | Return refused; raise illegal instruction |
| priv_out | output | 2 | Current privilege (11 machine, 00 user) |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational from csr_addr |

## Verification
The assertions assume that trap_req and mret_req are clean one-cycle pulses sampled at a clock edge, and that trap_code fits in CAUSE_W bits. They also assume no write strobe is counted as taking effect in a cycle that carries an event. The stimulus drives all inputs just after the falling edge and clears them before the next one. Random cause codes are masked to CAUSE_W bits. The random mix deliberately collides traps with returns and with writes, so that the priority rules are exercised rather than avoided.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_TRAP,
        EV_RET,
        EV_RET_BAD,
        EV_WRITE
    } ev_e;

    localparam logic [11:0] ADDR_STATUS = 12'h300;
    localparam logic [11:0] ADDR_TVEC   = 12'h305;
    localparam logic [11:0] ADDR_EPC    = 12'h341;
    localparam logic [11:0] ADDR_CAUSE  = 12'h342;
    localparam logic [11:0] ADDR_TVAL   = 12'h343;

    localparam int ST_IE_BIT   = 3;
    localparam int ST_PIE_BIT  = 7;
    localparam int ST_PP_LO    = 11;

    localparam logic [1:0] TVEC_DIRECT   = 2'd0;
    localparam logic [1:0] TVEC_VECTORED = 2'd1;

endpackage

// File: rtl/mtrap_state.sv
module mtrap_state
    import mtrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ev_e        ev,
    input  logic       wr_sel,
    input  logic       wr_ie,
    input  logic       wr_pie,
    input  logic [1:0] wr_pp,
    output logic [1:0] priv_q,
    output logic       ie_q,
    output logic       pie_q,
    output logic [1:0] pp_q
);

    priv_e      state_q, state_d;
    logic       ie_d, pie_d;
    logic [1:0] pp_d;
    logic       pp_legal;

    assign pp_legal = (wr_pp == PRIV_U) || (wr_pp == PRIV_M);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PRIV_M;
            ie_q    <= 1'b0;
            pie_q   <= 1'b0;
            pp_q    <= PRIV_U;
        end else begin
            state_q <= state_d;
            ie_q    <= ie_d;
            pie_q   <= pie_d;
            pp_q    <= pp_d;
        end
    end

    // transitions: TAKE_TRAP and RETURN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PRIV_M: begin
                if (ev == EV_RET)
                    state_d = (pp_q == PRIV_M) ? PRIV_M : PRIV_U;
            end
            PRIV_U: begin
                if (ev == EV_TRAP)
                    state_d = PRIV_M;
            end
            default: state_d = PRIV_M;
        endcase
    end

    // saved-state fields
    always_comb begin
        ie_d  = ie_q;
        pie_d = pie_q;
        pp_d  = pp_q;
        unique case (ev)
            EV_TRAP: begin
                pp_d  = state_q;
                pie_d = ie_q;
                ie_d  = 1'b0;
            end
            EV_RET: begin
                ie_d  = pie_q;
                pie_d = 1'b1;
                pp_d  = PRIV_U;
            end
            EV_WRITE: begin
                if (wr_sel) begin
                    ie_d  = wr_ie;
                    pie_d = wr_pie;
                    if (pp_legal)
                        pp_d = wr_pp;
                end
            end
            default: ;
        endcase
    end

    assign priv_q = state_q;

endmodule

// File: rtl/mtrap_vec.sv
module mtrap_vec
    import mtrap_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 5,
    parameter logic [31:0] RESET_TVEC = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ev_e                ev,
    input  logic               wr_sel,
    input  logic [XLEN-1:0]    wdata,
    input  logic               irq,
    input  logic [CAUSE_W-1:0] code,
    output logic [XLEN-3:0]    base_q,
    output logic [1:0]         mode_q,
    output logic [XLEN-1:0]    target
);

    localparam int PAD_W = XLEN - 2 - CAUSE_W;

    logic [XLEN-3:0] word_off;
    logic            mode_ok;

    assign mode_ok = (wdata[1:0] == TVEC_DIRECT) || (wdata[1:0] == TVEC_VECTORED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= RESET_TVEC[XLEN-1:2];
            mode_q <= RESET_TVEC[1:0];
        end else if (ev == EV_WRITE && wr_sel) begin
            base_q <= wdata[XLEN-1:2];
            if (mode_ok)
                mode_q <= wdata[1:0];
        end
    end

    always_comb begin
        if (irq && mode_q == TVEC_VECTORED)
            word_off = {{PAD_W{1'b0}}, code};
        else
            word_off = '0;
    end

    assign target = {base_q + word_off, 2'b00};

endmodule

// File: rtl/mtrap_info.sv
module mtrap_info
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ev_e                ev,
    input  logic [XLEN-3:0]    trap_pc_w,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_code,
    input  logic [XLEN-1:0]    trap_val,
    input  logic               sel_epc,
    input  logic               sel_cause,
    input  logic               sel_tval,
    input  logic [XLEN-1:0]    wdata,
    output logic [XLEN-3:0]    epc_q,
    output logic               cause_irq_q,
    output logic [CAUSE_W-1:0] cause_code_q,
    output logic [XLEN-1:0]    tval_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q        <= '0;
            cause_irq_q  <= 1'b0;
            cause_code_q <= '0;
            tval_q       <= '0;
        end else begin
            unique case (ev)
                EV_TRAP: begin
                    epc_q        <= trap_pc_w;
                    cause_irq_q  <= trap_irq;
                    cause_code_q <= trap_code;
                    tval_q       <= trap_val;
                end
                EV_WRITE: begin
                    if (sel_epc)
                        epc_q <= wdata[XLEN-1:2];
                    if (sel_cause) begin
                        cause_irq_q  <= wdata[XLEN-1];
                        cause_code_q <= wdata[CAUSE_W-1:0];
                    end
                    if (sel_tval)
                        tval_q <= wdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
    import mtrap_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 5,
    parameter logic [31:0] RESET_TVEC = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_code,
    input  logic [XLEN-1:0]    trap_val,
    input  logic               mret_req,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               mret_illegal,
    output logic [1:0]         priv_out,
    input  logic [11:0]        csr_addr,
    input  logic               csr_we,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata
);

    ev_e               ev;
    logic [1:0]        st_priv;
    logic              st_ie, st_pie;
    logic [1:0]        st_pp;
    logic [XLEN-3:0]   tv_base;
    logic [1:0]        tv_mode;
    logic [XLEN-1:0]   tv_target;
    logic [XLEN-3:0]   info_epc;
    logic              info_irq;
    logic [CAUSE_W-1:0] info_code;
    logic [XLEN-1:0]   info_tval;

    logic sel_status, sel_tvec, sel_epc, sel_cause, sel_tval;

    assign sel_status = (csr_addr == ADDR_STATUS);
    assign sel_tvec   = (csr_addr == ADDR_TVEC);
    assign sel_epc    = (csr_addr == ADDR_EPC);
    assign sel_cause  = (csr_addr == ADDR_CAUSE);
    assign sel_tval   = (csr_addr == ADDR_TVAL);

    // event decode, priority: trap, return, write
    always_comb begin
        if (trap_req)
            ev = EV_TRAP;
        else if (mret_req)
            ev = (st_priv == PRIV_M) ? EV_RET : EV_RET_BAD;
        else if (csr_we)
            ev = EV_WRITE;
        else
            ev = EV_IDLE;
    end

    mtrap_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .wr_sel (sel_status),
        .wr_ie  (csr_wdata[ST_IE_BIT]),
        .wr_pie (csr_wdata[ST_PIE_BIT]),
        .wr_pp  (csr_wdata[ST_PP_LO +: 2]),
        .priv_q (st_priv),
        .ie_q   (st_ie),
        .pie_q  (st_pie),
        .pp_q   (st_pp)
    );

    mtrap_vec #(
        .XLEN       (XLEN),
        .CAUSE_W    (CAUSE_W),
        .RESET_TVEC (RESET_TVEC)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .wr_sel (sel_tvec),
        .wdata  (csr_wdata),
        .irq    (trap_irq),
        .code   (trap_code),
        .base_q (tv_base),
        .mode_q (tv_mode),
        .target (tv_target)
    );

    mtrap_info #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_info (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .trap_pc_w    (trap_pc[XLEN-1:2]),
        .trap_irq     (trap_irq),
        .trap_code    (trap_code),
        .trap_val     (trap_val),
        .sel_epc      (sel_epc),
        .sel_cause    (sel_cause),
        .sel_tval     (sel_tval),
        .wdata        (csr_wdata),
        .epc_q        (info_epc),
        .cause_irq_q  (info_irq),
        .cause_code_q (info_code),
        .tval_q       (info_tval)
    );

    // event outputs
    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = {info_epc, 2'b00};
        mret_illegal   = 1'b0;
        unique case (ev)
            EV_TRAP: begin
                redirect_valid = 1'b1;
                redirect_pc    = tv_target;
            end
            EV_RET:     redirect_valid = 1'b1;
            EV_RET_BAD: mret_illegal   = 1'b1;
            default: ;
        endcase
    end

    // read port
    always_comb begin
        csr_rdata = '0;
        unique case (1'b1)
            sel_status: begin
                csr_rdata[ST_IE_BIT]    = st_ie;
                csr_rdata[ST_PIE_BIT]   = st_pie;
                csr_rdata[ST_PP_LO +: 2] = st_pp;
            end
            sel_tvec:  csr_rdata = {tv_base, tv_mode};
            sel_epc:   csr_rdata = {info_epc, 2'b00};
            sel_cause: begin
                csr_rdata[XLEN-1]      = info_irq;
                csr_rdata[CAUSE_W-1:0] = info_code;
            end
            sel_tval:  csr_rdata = info_tval;
            default: ;
        endcase
    end

    assign priv_out = st_priv;

endmodule

// File: rtl/mtrap_csr_unit_chk.sv
module mtrap_csr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [XLEN-1:0] trap_pc,
    input logic            mret_req,
    input logic            redirect_valid,
    input logic            mret_illegal,
    input logic [1:0]      priv_out,
    input logic            ie_q,
    input logic            pie_q,
    input logic [1:0]      pp_q,
    input logic [XLEN-3:0] epc_q
);

    // R2
    trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> epc_q == $past(trap_pc[XLEN-1:2]));

    // R3
    trap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (!ie_q && pie_q == $past(ie_q) && pp_q == $past(priv_out)
                      && priv_out == 2'b11));

    // R5
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_req && priv_out == 2'b11) |=>
        (priv_out == $past(pp_q) && ie_q == $past(pie_q) && pie_q && pp_q == 2'b00));

    // R6
    ret_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_req && priv_out != 2'b11) |-> (mret_illegal && !redirect_valid));

    // R6
    ret_refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_req && priv_out != 2'b11) |=>
        ($stable(priv_out) && $stable(ie_q) && $stable(pie_q) && $stable(pp_q)));

    // R7
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (redirect_valid && !mret_illegal));

    // R10
    pp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_q == 2'b00 || pp_q == 2'b11));

endmodule

bind mtrap_csr_unit mtrap_csr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_req       (trap_req),
    .trap_pc        (trap_pc),
    .mret_req       (mret_req),
    .redirect_valid (redirect_valid),
    .mret_illegal   (mret_illegal),
    .priv_out       (priv_out),
    .ie_q           (st_ie),
    .pie_q          (st_pie),
    .pp_q           (st_pp),
    .epc_q          (info_epc)
);

// File: tb/mtrap_csr_unit_tb.sv
`timescale 1ns/1ps
module mtrap_csr_unit_tb;

    localparam int XLEN = 32;
    localparam int CW   = 5;
    localparam logic [31:0] RV = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [XLEN-1:0] trap_pc = '0;
    logic            trap_irq = 1'b0;
    logic [CW-1:0]   trap_code = '0;
    logic [XLEN-1:0] trap_val = '0;
    logic            mret_req = 1'b0;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic            mret_illegal;
    logic [1:0]      priv_out;
    logic [11:0]     csr_addr = '0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;

    mtrap_csr_unit #(.XLEN(XLEN), .CAUSE_W(CW), .RESET_TVEC(RV)) u_dut (.*);

    always #2.5 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // reference state
    logic [1:0]  m_priv, m_pp, m_mode;
    logic        m_ie, m_pie, m_cirq;
    logic [29:0] m_base, m_epc;
    logic [CW-1:0] m_code;
    logic [31:0] m_tval;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            12'h300: begin v[3] = m_ie; v[7] = m_pie; v[12:11] = m_pp; end
            12'h305: v = {m_base, m_mode};
            12'h341: v = {m_epc, 2'b00};
            12'h342: begin v[31] = m_cirq; v[CW-1:0] = m_code; end
            12'h343: v = m_tval;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] exp_target(input logic irq, input logic [CW-1:0] code);
        if (irq && m_mode == 2'd1)
            return {m_base + 30'(code), 2'b00};
        return {m_base, 2'b00};
    endfunction

    task automatic model_reset();
        m_priv = 2'b11; m_pp = 2'b00; m_ie = 1'b0; m_pie = 1'b0;
        m_base = RV[31:2]; m_mode = RV[1:0];
        m_epc = '0; m_cirq = 1'b0; m_code = '0; m_tval = '0;
    endtask

    task automatic read_one(input string tag, input logic [11:0] a);
        csr_addr = a;
        #0.5;
        chk(tag, csr_rdata, exp_read(a));
    endtask

    // R12 address map read-back (called at the low clock phase)
    task automatic read_all(input string tag);
        read_one(tag, 12'h300);
        read_one(tag, 12'h305);
        read_one(tag, 12'h341);
        read_one(tag, 12'h342);
        read_one(tag, 12'h343);
        read_one(tag, 12'h7C0);
        chk({tag, " priv"}, {30'b0, priv_out}, {30'b0, m_priv});
        csr_addr = '0;
    endtask

    task automatic step(input logic t, input logic irq, input logic [CW-1:0] code,
                        input logic [31:0] pc, input logic [31:0] val, input logic r,
                        input logic we, input logic [11:0] a, input logic [31:0] wd);
        logic ok_ret, bad_ret;
        trap_req = t; trap_irq = irq; trap_code = code; trap_pc = pc; trap_val = val;
        mret_req = r; csr_we = we; csr_addr = a; csr_wdata = wd;
        #0.5;
        ok_ret  = !t && r && m_priv == 2'b11;
        bad_ret = !t && r && m_priv != 2'b11;
        chk("R4 R5 R7 redirect_valid", {31'b0, redirect_valid}, {31'b0, t || ok_ret});
        chk("R6 R7 mret_illegal", {31'b0, mret_illegal}, {31'b0, bad_ret});
        if (t)
            chk("R4 trap target", redirect_pc, exp_target(irq, code));
        else if (ok_ret)
            chk("R5 return target", redirect_pc, {m_epc, 2'b00});
        if (t) begin
            m_pp = m_priv; m_pie = m_ie; m_ie = 1'b0; m_priv = 2'b11;
            m_epc = pc[31:2]; m_cirq = irq; m_code = code; m_tval = val;
        end else if (ok_ret) begin
            m_priv = m_pp; m_ie = m_pie; m_pie = 1'b1; m_pp = 2'b00;
        end else if (!r && we) begin
            case (a)
                12'h300: begin
                    m_ie = wd[3]; m_pie = wd[7];
                    if (wd[12:11] == 2'b00 || wd[12:11] == 2'b11) m_pp = wd[12:11];
                end
                12'h305: begin
                    m_base = wd[31:2];
                    if (wd[1:0] < 2'd2) m_mode = wd[1:0];
                end
                12'h341: m_epc = wd[31:2];
                12'h342: begin m_cirq = wd[31]; m_code = wd[CW-1:0]; end
                12'h343: m_tval = wd;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        trap_req = 1'b0; mret_req = 1'b0; csr_we = 1'b0;
        trap_irq = 1'b0; trap_code = '0; trap_pc = '0; trap_val = '0;
        csr_addr = '0; csr_wdata = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        logic [11:0] addrs [6];
        int unsigned seed_dummy;
        addrs[0] = 12'h300; addrs[1] = 12'h305; addrs[2] = 12'h341;
        addrs[3] = 12'h342; addrs[4] = 12'h343; addrs[5] = 12'h7C0;
        seed_dummy = $urandom(32'd17);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_all("R1 reset");
        chk("R1 no redirect", {31'b0, redirect_valid}, 32'd0);

        // R8 vector mode writes
        wr(12'h305, 32'h0000_2001);
        read_one("R8 mode1", 12'h305);
        wr(12'h305, 32'h0000_3002);
        read_one("R8 reserved mode kept", 12'h305);
        wr(12'h305, 32'h0000_3003);
        read_one("R8 reserved mode 3 kept", 12'h305);

        // R2 R3 R4 exception in vectored mode goes to base
        step(1'b1, 1'b0, 5'd2, 32'h0000_1236, 32'hDEAD_BEEF, 1'b0, 1'b0, '0, '0);
        read_all("R2 R3 R9 after exception");

        // R10 illegal MPP write ignored, other fields written
        wr(12'h300, 32'h0000_0888);
        read_one("R10 pp 01 ignored", 12'h300);
        wr(12'h300, 32'h0000_1008);
        read_one("R10 pp 10 ignored", 12'h300);
        wr(12'h300, 32'h0000_0008);
        read_one("R10 pp 00 taken", 12'h300);

        // R9 mepc write drops low bits
        wr(12'h341, 32'h0000_4447);
        read_one("R9 epc aligned", 12'h341);

        // R5 return to user
        step(1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, '0, '0);
        read_all("R5 after return");

        // R6 return from user refused
        step(1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, '0, '0);
        read_all("R6 refused return");

        // R4 vectored interrupt from user, code 7
        step(1'b1, 1'b1, 5'd7, 32'h0000_5000, 32'h0, 1'b0, 1'b0, '0, '0);
        read_all("R3 R4 after interrupt");

        // R7 trap and return together
        step(1'b1, 1'b0, 5'd11, 32'h0000_6000, 32'h0, 1'b1, 1'b0, '0, '0);
        read_all("R7 collision");

        // R11 write dropped with a trap / with a return
        step(1'b1, 1'b0, 5'd3, 32'h0000_7000, 32'h1, 1'b0, 1'b1, 12'h343, 32'h1234_5678);
        read_one("R11 write vs trap", 12'h343);
        step(1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b1, 12'h343, 32'hAAAA_5555);
        read_one("R11 write vs return", 12'h343);

        // R12 unmapped write
        wr(12'h7C0, 32'hFFFF_FFFF);
        read_all("R12 unmapped");

        // R4 direct mode: interrupt goes to base
        wr(12'h305, 32'h0000_8000);
        step(1'b1, 1'b1, 5'd9, 32'h0000_9000, 32'h0, 1'b0, 1'b0, '0, '0);
        read_all("R4 direct mode");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            logic [31:0] d;
            logic [11:0] a;
            op = $urandom % 8;
            d  = $urandom;
            a  = addrs[$urandom % 6];
            case (op)
                0, 1: step(1'b1, d[0], 5'($urandom), $urandom, $urandom, 1'b0, 1'b0, '0, '0);
                2, 3: step(1'b0, 1'b0, '0, '0, '0, 1'b1, d[1], a, $urandom);
                7:    step(1'b1, d[0], 5'($urandom), $urandom, $urandom, 1'b1, d[1], a, $urandom);
                default: wr(a, d);
            endcase
            read_all("R2 R3 R5 R8 R10 R11 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule